// File: doc/BRIEF.md
# Multichannel Sinusoidal PWM Generator with Direct Digital Synthesis

The block turns a run-time frequency word and a set of per-channel phase words into several sinusoidally modulated PWM bits. A phase accumulator advances by the frequency word once per carrier period. Each channel adds its own phase word to the accumulator. It uses the top bits of that sum to read an offset-binary sine table.

A single up/down counter sweeps a symmetric digital triangle between zero and the full-scale sample code. The block itself generates that counter's step enable and its direction. Each channel holds one sine sample for a whole triangle period. It compares that sample with the sweeping count to form its PWM bit. New frequency and phase words are picked up only at a period boundary, so a pulse is never cut short in mid-period. An external low-pass filter on each PWM pin recovers the sine wave.

Top module: `spwm_dds_gen`

## Requirements
- R1: While `rst` is high at a clock edge, every PWM bit is 0 after that edge. Reset also clears the accumulator and every latched phase word, sets each held sample to midscale 2^(SAMP_W-1), and puts the carrier at count 0 with direction up.
- R2: The carrier advances one step every CAR_DIV clocks. It runs 0,1,…,2^SAMP_W−1,2^SAMP_W−2,…,1,0,1,… and repeats neither end value, so one period lasts 2·(2^SAMP_W−1)·CAR_DIV clocks.
- R3: A period starts at each carrier step taken from count 0. At that edge the accumulator adds the `freq_word` sampled there, and at no other edge does the accumulator change.
- R4: At a period start each channel latches its phase word. Channel c uses bits [c·ACC_W +: ACC_W] of `phase_words`. The table address is the top ADDR_W bits of (accumulator + latched phase word), taken modulo 2^ACC_W.
- R5: A held sample changes only at a period start. It then takes the table entry addressed by the accumulator and phase word that were in force during the period just ended.
- R6: Each PWM bit is registered. After an edge it equals (held sample > carrier count), using the values those had before that edge.
- R7: Table entry i holds round(2^(SAMP_W-1) + (2^(SAMP_W-1)−1)·sin(2πi/2^ADDR_W)). With the defaults, entry 0 is 128, entry 64 is 255 and entry 192 is 1, so the PWM is high for 510, 1018 and 2 clocks of each 1020-clock period.
- R8: A change of `freq_word` or `phase_words` between period starts has no effect on any PWM bit until the next period start.
- R9: Channels are independent. Each channel's output depends only on the shared accumulator, the shared carrier and its own phase word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| freq_word | input | ACC_W | Accumulator increment per carrier period |
| phase_words | input | CHANNELS·ACC_W | Per-channel phase offsets, channel c at [c·ACC_W +: ACC_W] |
| pwm | output | CHANNELS | Registered PWM bits, one per channel |

## Verification
Each PWM bit is due one clock after the carrier count or held sample it reflects. Frequency and phase words sampled at a period start reach the held sample at the following period start, one full period later. The bench runs a cycle-accurate reference model on the rising edge from the same inputs. It drives inputs and compares every PWM bit on the falling edge, so each comparison lines up with the edge the result is due on. Directed duty counts over one whole period pin down the table values and the carrier range, and random mid-period word changes probe the period-boundary rule.

// File: rtl/spwm_pkg.sv
package spwm_pkg;

  localparam real TWO_PI = 6.283185307179586;

  // Offset-binary sine code for table entry idx (R7).
  function automatic int sine_code(int idx, int addr_w, int samp_w);
    real mid;
    real ang;
    mid = 2.0 ** (samp_w - 1);
    ang = TWO_PI * idx / (2.0 ** addr_w);
    return $rtoi(mid + (mid - 1.0) * $sin(ang) + 0.5);
  endfunction

endpackage

// File: rtl/spwm_carrier.sv
module spwm_carrier #(
  parameter int SAMP_W  = 8,
  parameter int CAR_DIV = 2
) (
  input  logic              clk,
  input  logic              rst,
  output logic [SAMP_W-1:0] cnt_o,
  output logic              up_o,
  output logic              start_o
);

  localparam logic [SAMP_W-1:0] TOP    = {SAMP_W{1'b1}};
  localparam logic [SAMP_W-1:0] ZERO   = '0;
  localparam logic [SAMP_W-1:0] ONE    = SAMP_W'(1);

  logic strobe;

  generate
    if (CAR_DIV <= 1) begin : g_nodiv
      assign strobe = 1'b1;
    end else begin : g_div
      localparam int PRE_W = $clog2(CAR_DIV);
      localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CAR_DIV - 1);
      logic [PRE_W-1:0] pre_q;
      always_ff @(posedge clk) begin
        if (rst)                  pre_q <= '0;
        else if (pre_q == PRE_LAST) pre_q <= '0;
        else                      pre_q <= pre_q + PRE_W'(1);
      end
      assign strobe = (pre_q == PRE_LAST);
    end
  endgenerate

  // Reversible triangle counter, turning at both ends without repeats.
  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_o <= ZERO;
      up_o  <= 1'b1;
    end else if (strobe) begin
      if (up_o) begin
        if (cnt_o == TOP) begin
          cnt_o <= TOP - ONE;
          up_o  <= 1'b0;
        end else begin
          cnt_o <= cnt_o + ONE;
        end
      end else begin
        if (cnt_o == ZERO) begin
          cnt_o <= ONE;
          up_o  <= 1'b1;
        end else begin
          cnt_o <= cnt_o - ONE;
        end
      end
    end
  end

  assign start_o = strobe && (cnt_o == ZERO);

  // R2: counter is frozen between enable strobes
  p_idle_r2: assert property (@(posedge clk) disable iff (rst)
    !strobe |=> ($stable(cnt_o) && $stable(up_o)));
  // R2: top end turns down without repeating the top value
  p_top_turn_r2: assert property (@(posedge clk) disable iff (rst)
    (strobe && cnt_o == TOP) |=> (cnt_o == TOP - ONE && !up_o));
  // R2: bottom end turns up without repeating zero
  p_bottom_turn_r2: assert property (@(posedge clk) disable iff (rst)
    (strobe && cnt_o == ZERO) |=> (cnt_o == ONE && up_o));

endmodule

// File: rtl/spwm_phase_acc.sv
module spwm_phase_acc #(
  parameter int ACC_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [ACC_W-1:0] freq_word,
  output logic [ACC_W-1:0] acc_o
);

  always_ff @(posedge clk) begin
    if (rst)        acc_o <= '0;
    else if (start) acc_o <= acc_o + freq_word;
  end

  // R3: accumulator moves only at a period start
  p_acc_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !start |=> $stable(acc_o));

endmodule

// File: rtl/spwm_sine_rom.sv
module spwm_sine_rom #(
  parameter int ADDR_W = 8,
  parameter int SAMP_W = 8
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] addr,
  output logic [SAMP_W-1:0] q
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [SAMP_W-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++)
      mem[i] = SAMP_W'(spwm_pkg::sine_code(i, ADDR_W, SAMP_W));
  end

  // Registered read, no reset: maps onto block RAM.
  always_ff @(posedge clk) q <= mem[addr];

endmodule

// File: rtl/spwm_channel.sv
module spwm_channel #(
  parameter int ACC_W  = 16,
  parameter int ADDR_W = 8,
  parameter int SAMP_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ACC_W-1:0]  acc,
  input  logic [ACC_W-1:0]  ph_word,
  input  logic [SAMP_W-1:0] cnt,
  output logic              pwm_o
);

  localparam int SHIFT = ACC_W - ADDR_W;
  localparam logic [SAMP_W-1:0] MID = {1'b1, {(SAMP_W-1){1'b0}}};

  logic [ACC_W-1:0]  ph_q;
  logic [ACC_W-1:0]  sum;
  logic [ADDR_W-1:0] addr;
  logic [SAMP_W-1:0] rom_q;
  logic [SAMP_W-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (rst)        ph_q <= '0;
    else if (start) ph_q <= ph_word;
  end

  assign sum  = acc + ph_q;
  assign addr = ADDR_W'(sum >> SHIFT);

  spwm_sine_rom #(.ADDR_W(ADDR_W), .SAMP_W(SAMP_W)) u_rom (
    .clk  (clk),
    .addr (addr),
    .q    (rom_q)
  );

  // rom_q was fetched during the period now ending.
  always_ff @(posedge clk) begin
    if (rst)        hold_q <= MID;
    else if (start) hold_q <= rom_q;
  end

  always_ff @(posedge clk) begin
    if (rst) pwm_o <= 1'b0;
    else     pwm_o <= (hold_q > cnt);
  end

  // R5: held sample is constant between period starts
  p_hold_stable_r5: assert property (@(posedge clk) disable iff (rst)
    !start |=> $stable(hold_q));
  // R8: latched phase word is constant between period starts
  p_phase_stable_r8: assert property (@(posedge clk) disable iff (rst)
    !start |=> $stable(ph_q));

endmodule

// File: rtl/spwm_dds_gen.sv
module spwm_dds_gen #(
  parameter int ACC_W    = 16,
  parameter int ADDR_W   = 8,
  parameter int SAMP_W   = 8,
  parameter int CHANNELS = 3,
  parameter int CAR_DIV  = 2
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [ACC_W-1:0]          freq_word,
  input  logic [CHANNELS*ACC_W-1:0] phase_words,
  output logic [CHANNELS-1:0]       pwm
);

  logic [SAMP_W-1:0] car_cnt;
  logic              car_up;
  logic              period_start;
  logic [ACC_W-1:0]  acc;

  spwm_carrier #(.SAMP_W(SAMP_W), .CAR_DIV(CAR_DIV)) u_carrier (
    .clk     (clk),
    .rst     (rst),
    .cnt_o   (car_cnt),
    .up_o    (car_up),
    .start_o (period_start)
  );

  spwm_phase_acc #(.ACC_W(ACC_W)) u_acc (
    .clk       (clk),
    .rst       (rst),
    .start     (period_start),
    .freq_word (freq_word),
    .acc_o     (acc)
  );

  generate
    for (genvar c = 0; c < CHANNELS; c++) begin : g_ch
      spwm_channel #(.ACC_W(ACC_W), .ADDR_W(ADDR_W), .SAMP_W(SAMP_W)) u_ch (
        .clk     (clk),
        .rst     (rst),
        .start   (period_start),
        .acc     (acc),
        .ph_word (phase_words[c*ACC_W +: ACC_W]),
        .cnt     (car_cnt),
        .pwm_o   (pwm[c])
      );
    end
  endgenerate

  // R1: outputs are low in the cycle after a reset edge
  p_reset_low_r1: assert property (@(posedge clk)
    rst |=> (pwm == '0));
  // R3: a period starts only from count 0 while heading up or turning
  p_start_at_zero_r3: assert property (@(posedge clk) disable iff (rst)
    period_start |=> (car_cnt == SAMP_W'(1) && car_up));

endmodule

// File: tb/tb_spwm_dds_gen.sv
module tb_spwm_dds_gen;

  localparam int ACC_W  = 16;
  localparam int ADDR_W = 8;
  localparam int SAMP_W = 8;
  localparam int CH     = 3;
  localparam int DIV    = 2;
  localparam int TOPV   = (1 << SAMP_W) - 1;
  localparam int PERIOD = 2 * TOPV * DIV;
  localparam int DEPTH  = 1 << ADDR_W;

  logic                   clk = 1'b0;
  logic                   rst = 1'b1;
  logic [ACC_W-1:0]       freq_word = '0;
  logic [CH*ACC_W-1:0]    phase_words = '0;
  logic [CH-1:0]          pwm;

  always #2 clk = ~clk;

  spwm_dds_gen #(.ACC_W(ACC_W), .ADDR_W(ADDR_W), .SAMP_W(SAMP_W),
                 .CHANNELS(CH), .CAR_DIV(DIV)) dut (
    .clk (clk), .rst (rst), .freq_word (freq_word),
    .phase_words (phase_words), .pwm (pwm)
  );

  int compared = 0;
  int mismatched = 0;
  bit done = 0;
  bit chk_on = 0;
  string tag = "R1";

  // Independent sine reference per R7.
  int tbl [DEPTH];
  function automatic int ref_sine(int i);
    real m;
    real a;
    m = 2.0 ** (SAMP_W - 1);
    a = 6.283185307179586 * i / (2.0 ** ADDR_W);
    return $rtoi(m + (m - 1.0) * $sin(a) + 0.5);
  endfunction

  function automatic int duty_clocks(int h);
    if (h <= 0) return 0;
    return (1 + 2 * (h - 1)) * DIV;
  endfunction

  // Reference model updated at each rising edge.
  int m_cnt, m_up, m_pre;
  logic [ACC_W-1:0] m_acc;
  logic [ACC_W-1:0] m_ph [CH];
  int m_hold [CH];
  bit m_pwm [CH];
  bit m_strobe, m_start;
  logic [ACC_W-1:0] m_sum;

  always @(posedge clk) begin
    if (rst) begin
      m_cnt = 0; m_up = 1; m_pre = 0; m_acc = '0;
      for (int c = 0; c < CH; c++) begin
        m_ph[c] = '0; m_hold[c] = 1 << (SAMP_W - 1); m_pwm[c] = 0;
      end
    end else begin
      m_strobe = (m_pre == DIV - 1);
      m_start  = m_strobe && (m_cnt == 0);
      for (int c = 0; c < CH; c++) m_pwm[c] = (m_hold[c] > m_cnt);
      if (m_start) begin
        for (int c = 0; c < CH; c++) begin
          m_sum = m_acc + m_ph[c];
          m_hold[c] = tbl[int'(m_sum >> (ACC_W - ADDR_W))];
          m_ph[c] = phase_words[c*ACC_W +: ACC_W];
        end
        m_acc = m_acc + freq_word;
      end
      if (m_strobe) begin
        if (m_up == 1) begin
          if (m_cnt == TOPV) begin m_cnt = TOPV - 1; m_up = 0; end
          else m_cnt = m_cnt + 1;
        end else begin
          if (m_cnt == 0) begin m_cnt = 1; m_up = 1; end
          else m_cnt = m_cnt - 1;
        end
      end
      m_pre = m_strobe ? 0 : m_pre + 1;
    end
  end

  // Continuous comparison on the falling edge.
  always @(negedge clk) begin
    if (chk_on && !rst) begin
      for (int c = 0; c < CH; c++) begin
        compared++;
        if (pwm[c] !== m_pwm[c]) begin
          mismatched++;
          $display("FAIL %s ch%0d: pwm got %0b expected %0b at %0t",
                   tag, c, pwm[c], m_pwm[c], $time);
        end
      end
    end
  end

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
  endtask

  task automatic set_phases(int p0, int p1, int p2);
    phase_words = {ACC_W'(p2), ACC_W'(p1), ACC_W'(p0)};
  endtask

  task automatic rand_words();
    freq_word = ACC_W'($urandom);
    for (int c = 0; c < CH; c++) phase_words[c*ACC_W +: ACC_W] = ACC_W'($urandom);
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) tbl[i] = ref_sine(i);
    void'($urandom(32'h5EED1234));

    // R1: outputs low under reset
    repeat (4) @(negedge clk);
    for (int c = 0; c < CH; c++) begin
      compared++;
      if (pwm[c] !== 1'b0) begin
        mismatched++;
        $display("FAIL R1 ch%0d: pwm got %0b expected 0 in reset", c, pwm[c]);
      end
    end

    // R2 R7: directed duty counts with frozen accumulator
    set_phases(16'h0000, 16'h4000, 16'hC000);
    freq_word = '0;
    rst = 1'b0;
    tag = "R1";
    chk_on = 1;
    repeat (PERIOD) @(negedge clk);
    tag = "R6";
    repeat (3 * PERIOD) @(negedge clk);
    begin
      int highs [CH];
      int expv [CH];
      expv[0] = duty_clocks(tbl[0]);
      expv[1] = duty_clocks(tbl[64]);
      expv[2] = duty_clocks(tbl[192]);
      for (int c = 0; c < CH; c++) highs[c] = 0;
      repeat (PERIOD) begin
        @(negedge clk);
        for (int c = 0; c < CH; c++) highs[c] += int'(pwm[c]);
      end
      for (int c = 0; c < CH; c++) begin
        compared++;
        if (highs[c] != expv[c]) begin
          mismatched++;
          $display("FAIL R2 R7 ch%0d: high clocks got %0d expected %0d",
                   c, highs[c], expv[c]);
        end
      end
      // R7: literal table values at the quarter points
      compared++;
      if (expv[0] != 510 || expv[1] != 1018 || expv[2] != 2) begin
        mismatched++;
        $display("FAIL R7 duty table got %0d/%0d/%0d expected 510/1018/2",
                 expv[0], expv[1], expv[2]);
      end
    end

    // R3: random frequency words held for two periods each
    tag = "R3";
    repeat (10) begin
      freq_word = ACC_W'($urandom);
      repeat (2 * PERIOD) @(negedge clk);
    end

    // R4: random phase words
    tag = "R4";
    repeat (6) begin
      rand_words();
      repeat (2 * PERIOD) @(negedge clk);
    end

    // R5 R8: words change at random points inside periods
    tag = "R5 R8";
    repeat (80) begin
      repeat ($urandom_range(1, 300)) @(negedge clk);
      rand_words();
    end

    // R9: distinct per-channel phases on a common frequency
    tag = "R9";
    freq_word = 16'h0123;
    set_phases(16'h0000, 16'h5555, 16'hAAAA);
    repeat (5 * PERIOD) @(negedge clk);

    // R1: reset mid-run returns outputs low
    rst = 1'b1;
    chk_on = 0;
    @(negedge clk);
    @(negedge clk);
    for (int c = 0; c < CH; c++) begin
      compared++;
      if (pwm[c] !== 1'b0) begin
        mismatched++;
        $display("FAIL R1 ch%0d: pwm got %0b expected 0 after reset", c, pwm[c]);
      end
    end
    rst = 1'b0;
    tag = "R1";
    chk_on = 1;
    repeat (PERIOD) @(negedge clk);

    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: run got hung expected completion");
      summary();
      $finish;
    end
  end

endmodule